// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the device side of a four-wire serial bus for a small byte-wide nonvolatile-style memory. It oversamples chip select, serial clock, serial data in and an active-low hold input on the chip clock, and it drives serial data out together with an output-enable that a pad uses to float the line. Each selected transfer starts with an 8-bit command. Memory commands then take an address, sent as one byte when the address is eight bits or fewer and as two bytes otherwise, with the unused upper bits ignored. Data bytes follow the address. The memory itself is a register array inside the block. A separate protection block grants write permission through a single input.

Bits are captured on rising serial-clock edges and launched on falling edges, most significant bit first. The serial clock may idle low (mode 0) or high (mode 3). A read streams consecutive bytes for as long as the host keeps clocking, and the address wraps from the last location to zero. Writes also advance the address and wrap. Taking hold low while the block is selected freezes the transfer and floats the output. Releasing hold resumes the transfer at the next bit.

The command sequencer is a state machine with these states:
- `ST_IDLE`: not selected.
- `ST_OPCODE`: collecting the command byte.
- `ST_ADDR`: collecting the address bytes.
- `ST_READ`: streaming array data out.
- `ST_WRITE`: storing received bytes.
- `ST_STAT_RD`: streaming the status byte.
- `ST_STAT_WR`: taking one status byte.
- `ST_DISCARD`: ignoring the bus until deselect.

Transitions:
- Selection moves `ST_IDLE` to `ST_OPCODE`.
- A complete command byte leaves `ST_OPCODE`:
  - read, and a permitted write, go to `ST_ADDR`;
  - status read goes to `ST_STAT_RD`;
  - a permitted status write goes to `ST_STAT_WR`;
  - everything else goes to `ST_DISCARD`.
- The last address byte leaves `ST_ADDR` for `ST_READ` or `ST_WRITE`.
- One complete byte moves `ST_STAT_WR` to `ST_DISCARD`.
- Deselection returns every state to `ST_IDLE`.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, and whenever chip select is high, the output enable is 0. While the block is selected and hold is high, the output enable is 1.
- R2: In both mode 0 (clock idles low) and mode 3 (clock idles high), input bits are taken on the rising clock edge and output bits change on the falling edge. Both directions are most significant bit first, and each command and each address byte is one 8-bit byte.
- R3: Command 06h sets the write-enable flag and command 04h clears it. Command 05h returns the status byte, repeated for every further byte clocked out. The status byte is {user bits [7:2], write-enable at bit 1, 0 at bit 0}.
- R4: Command 02h, when the write-enable flag is 1 and wr_allow is 1, stores each complete data byte at an address that starts at the given address and increments. The write-enable flag clears when chip select rises after such a write.
- R5: A 02h command sent while the write-enable flag is 0, or while wr_allow is 0, changes no memory location and leaves the flag as it was.
- R6: Command 03h returns the byte at the given address and then the following bytes, one per byte clocked. The address wraps from the last location to 0, and writes wrap the same way.
- R7: Raising chip select discards a partially received byte and restarts bit counting. A write commits only complete bytes.
- R8: While the block is selected and hold is low, the output enable is 0 and clock edges are ignored. After hold is released the transfer continues at the next bit with its state intact.
- R9: A command byte other than 06h, 04h, 05h, 01h, 03h and 02h makes the block ignore all further bits until chip select rises. It changes neither the status nor the memory.
- R10: Command 01h, when the write-enable flag is 1 and wr_allow is 1, loads bits [7:2] of the next byte into status bits [7:2] (bits [1:0] of that byte are ignored) and clears the write-enable flag at deselect. Without that permission the command has no effect.
- R11: Reset sets every memory location to FFh and the status byte to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data into the block |
| spi_hold_n | input | 1 | Active-low hold that pauses the transfer |
| wr_allow | input | 1 | Write permission from the protection block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for spi_miso (0 means high impedance) |

## Verification
The bench drives these corner cases, each checked against its own memory model:
- A write that runs past the top of the array must land at location 0. A design that saturates its address, or that computes the wrap from the wrong width, leaves location 0 holding FFh.
- A transfer cut off after five bits of a data byte must leave that location unchanged. A design that commits on deselect would store a shifted fragment.
- Hold is asserted in the middle of a data byte and several clock pulses are sent during the hold. A design that counted those pulses would return a misaligned byte or keep driving the output.
- An unknown command, a write without permission and a status write without permission are each followed by reading back the status and memory. Both transfers are repeated with the clock idling high, which catches a design that shifts on the wrong edge or loses the first bit when selection starts with the clock high.

// File: rtl/memslv_pkg.sv
package memslv_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_READ,
        ST_WRITE,
        ST_STAT_RD,
        ST_STAT_WR,
        ST_DISCARD
    } memslv_state_e;

endpackage

// File: rtl/memslv_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
module memslv_sync #(
    parameter int WIDTH = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            chain_q[0] <= din;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/memslv_shifter.sv
// Bit counter, receive shifter and transmit shifter for the serial link.
module memslv_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       rise,
    input  logic       fall,
    input  logic       mosi,
    input  logic       load,
    input  logic [7:0] load_data,
    output logic [7:0] rx_full,
    output logic       byte_done,
    output logic [2:0] bit_cnt,
    output logic       miso
);
    logic [6:0] rx_q;
    logic [7:0] tx_q;
    logic [2:0] cnt_q;
    logic       miso_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q   <= '0;
            tx_q   <= '0;
            cnt_q  <= '0;
            miso_q <= 1'b0;
        end else if (!sel) begin
            cnt_q <= '0;
        end else begin
            if (rise) begin
                rx_q  <= {rx_q[5:0], mosi};
                cnt_q <= cnt_q + 3'd1;
            end
            if (load) begin
                tx_q <= load_data;
            end else if (fall) begin
                miso_q <= tx_q[7];
                tx_q   <= {tx_q[6:0], 1'b0};
            end
        end
    end

    assign rx_full   = {rx_q, mosi};
    assign byte_done = rise && (cnt_q == 3'd7);
    assign bit_cnt   = cnt_q;
    assign miso      = miso_q;
endmodule

// File: rtl/memslv_array.sv
// Byte-wide storage, combinational read, one write port.
module memslv_array #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= 8'hFF;
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import memslv_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    input  logic spi_hold_n,
    input  logic wr_allow,
    output logic spi_miso,
    output logic spi_miso_oe
);
    localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
    localparam int ABW = 2;

    // pin synchronizer: {cs_n, sck, mosi, hold_n}
    logic [3:0] pins_s;
    memslv_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({spi_cs_n, spi_sck, spi_mosi, spi_hold_n}),
        .dout(pins_s)
    );

    logic cs_s, sck_s, mosi_s, hold_s, sck_d;
    assign cs_s   = pins_s[3];
    assign sck_s  = pins_s[2];
    assign mosi_s = pins_s[1];
    assign hold_s = pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    logic sel, sck_rise_v, sck_fall_v;
    assign sel        = !cs_s;
    assign sck_rise_v = sel && hold_s && sck_s && !sck_d;
    assign sck_fall_v = sel && hold_s && !sck_s && sck_d;

    // shifter
    logic       tx_load, byte_done;
    logic [7:0] tx_data, rx_full;
    logic [2:0] bit_cnt;
    memslv_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .rise(sck_rise_v), .fall(sck_fall_v), .mosi(mosi_s),
        .load(tx_load), .load_data(tx_data),
        .rx_full(rx_full), .byte_done(byte_done), .bit_cnt(bit_cnt),
        .miso(spi_miso)
    );

    // storage
    logic              mem_we;
    logic [ADDR_W-1:0] addr_q, addr_nxt, addr_shift, rd_addr;
    logic [7:0]        rd_data;
    memslv_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(addr_q), .wdata(rx_full),
        .raddr(rd_addr), .rdata(rd_data)
    );

    // sequencer registers
    memslv_state_e  state_q, state_d;
    logic [ABW-1:0] abyte_q;
    logic           op_read_q, wel_q, wrote_q;
    logic [5:0]     sr_user_q;
    logic [7:0]     status_byte;
    logic           wel_set, wel_clr, sr_we, addr_ld, last_abyte, wr_ok;

    assign status_byte = {sr_user_q, wel_q, 1'b0};
    assign addr_shift  = ADDR_W'({addr_q, rx_full});
    assign last_abyte  = (abyte_q == ABW'(ADDR_BYTES - 1));
    assign wr_ok       = wel_q && wr_allow;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!sel) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_OPCODE;
                ST_OPCODE: begin
                    if (byte_done) begin
                        unique case (rx_full)
                            OP_READ:  state_d = ST_ADDR;
                            OP_WRITE: state_d = wr_ok ? ST_ADDR : ST_DISCARD;
                            OP_RDSR:  state_d = ST_STAT_RD;
                            OP_WRSR:  state_d = wr_ok ? ST_STAT_WR : ST_DISCARD;
                            default:  state_d = ST_DISCARD;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (byte_done && last_abyte)
                        state_d = op_read_q ? ST_READ : ST_WRITE;
                end
                ST_STAT_WR: if (byte_done) state_d = ST_DISCARD;
                ST_READ, ST_WRITE, ST_STAT_RD, ST_DISCARD: state_d = state_q;
            endcase
        end
    end

    // outputs of the sequencer
    always_comb begin
        tx_load  = 1'b0;
        tx_data  = 8'h00;
        mem_we   = 1'b0;
        sr_we    = 1'b0;
        wel_set  = 1'b0;
        wel_clr  = 1'b0;
        addr_ld  = 1'b0;
        addr_nxt = addr_q;
        rd_addr  = addr_q;
        unique case (state_q)
            ST_OPCODE: begin
                if (byte_done) begin
                    if (rx_full == OP_WREN) wel_set = 1'b1;
                    if (rx_full == OP_WRDI) wel_clr = 1'b1;
                    if (rx_full == OP_RDSR) begin
                        tx_load = 1'b1;
                        tx_data = status_byte;
                    end
                end
            end
            ST_ADDR: begin
                if (byte_done) begin
                    addr_ld  = 1'b1;
                    addr_nxt = addr_shift;
                    if (last_abyte && op_read_q) begin
                        rd_addr  = addr_shift;
                        tx_load  = 1'b1;
                        tx_data  = rd_data;
                        addr_nxt = addr_shift + ADDR_W'(1);
                    end
                end
            end
            ST_READ: begin
                if (byte_done) begin
                    tx_load  = 1'b1;
                    tx_data  = rd_data;
                    addr_ld  = 1'b1;
                    addr_nxt = addr_q + ADDR_W'(1);
                end
            end
            ST_WRITE: begin
                if (byte_done) begin
                    mem_we   = 1'b1;
                    addr_ld  = 1'b1;
                    addr_nxt = addr_q + ADDR_W'(1);
                end
            end
            ST_STAT_RD: begin
                if (byte_done) begin
                    tx_load = 1'b1;
                    tx_data = status_byte;
                end
            end
            ST_STAT_WR: if (byte_done) sr_we = 1'b1;
            ST_IDLE, ST_DISCARD: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            abyte_q   <= '0;
            op_read_q <= 1'b0;
            wel_q     <= 1'b0;
            wrote_q   <= 1'b0;
            sr_user_q <= '0;
        end else if (!sel) begin
            addr_q  <= '0;
            abyte_q <= '0;
            if (wrote_q) begin
                wel_q   <= 1'b0;
                wrote_q <= 1'b0;
            end
        end else begin
            if (wel_set) wel_q <= 1'b1;
            if (wel_clr) wel_q <= 1'b0;
            if (state_q == ST_OPCODE && byte_done) op_read_q <= (rx_full == OP_READ);
            if (state_q == ST_ADDR && byte_done) abyte_q <= abyte_q + ABW'(1);
            if (addr_ld) addr_q <= addr_nxt;
            if (mem_we) wrote_q <= 1'b1;
            if (sr_we) begin
                sr_user_q <= rx_full[7:2];
                wrote_q   <= 1'b1;
            end
        end
    end

    assign spi_miso_oe = sel && hold_s;
endmodule

// File: rtl/memslv_checker.sv
module memslv_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_hold_n,
    input logic       spi_miso,
    input logic       spi_miso_oe,
    input logic       sck_fall_v,
    input logic       mem_we,
    input logic       sr_we,
    input logic       wel_q,
    input logic       sel,
    input logic [2:0] bit_cnt
);
    // R1: a chip select held high for three samples floats the output
    a_r1_cs_high_floats: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso_oe);

    // R8: a hold held low for three samples floats the output
    a_r8_hold_floats: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_hold_n && !$past(spi_hold_n) && !$past(spi_hold_n, 2)) |-> !spi_miso_oe);

    // R2: data out only moves after an accepted falling edge
    a_r2_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_miso) |-> $past(sck_fall_v));

    // R4 / R5: memory is written only with the write-enable flag set
    a_r5_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel_q);

    // R10: status write only with the write-enable flag set
    a_r10_sr_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |-> wel_q);

    // R7: deselect restarts bit counting
    a_r7_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (bit_cnt == 3'd0));
endmodule

bind spi_mem_slave memslv_checker u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_hold_n(spi_hold_n),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .sck_fall_v(sck_fall_v),
    .mem_we(mem_we), .sr_we(sr_we), .wel_q(wel_q), .sel(sel), .bit_cnt(bit_cnt)
);

// File: tb/test_spi_mem_slave.sv
`timescale 1ns/1ps
module test_spi_mem_slave;
    localparam int AW = 9;
    localparam int DEPTH = 1 << AW;
    localparam int HALF = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, wr_allow = 1'b1;
    logic miso, oe;
    logic cpol = 1'b0;

    always #5 clk = ~clk;

    spi_mem_slave #(.ADDR_W(AW)) i_spi_mem_slave (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_hold_n(hold_n), .wr_allow(wr_allow),
        .spi_miso(miso), .spi_miso_oe(oe)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] model [DEPTH];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] rx_val;
    event       rx_ev;
    bit         finished = 0;

    task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(rx_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard-underflow", rx_val, 8'h00);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rx_val === e, t, rx_val, e);
            end
        end
    end

    task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b0; mosi = tx[7-i]; #(HALF);
            rx[7-i] = miso;
            sck = 1'b1; #(HALF);
            if (i == hold_at) begin
                hold_n = 1'b0; #(HALF);
                chk(oe == 1'b0, "R8 hold floats output", {7'd0, oe}, 8'h00);
                for (int k = 0; k < 3; k++) begin
                    sck = 1'b0; mosi = ~mosi; #(HALF);
                    sck = 1'b1; #(HALF);
                end
                hold_n = 1'b1; #(HALF);
            end
        end
    endtask

    task automatic tx_byte(input logic [7:0] b);
        logic [7:0] d;
        xfer(b, 8, -1, d);
    endtask

    task automatic begin_tr();
        sck = cpol; #(HALF);
        cs_n = 1'b0; #(HALF);
    endtask

    task automatic end_tr();
        sck = cpol; #(HALF);
        cs_n = 1'b1; #(2*HALF);
    endtask

    task automatic send_addr(input int a);
        logic [15:0] a16;
        a16 = 16'(a);
        tx_byte(a16[15:8]);
        tx_byte(a16[7:0]);
    endtask

    task automatic cmd1(input logic [7:0] op);
        begin_tr(); tx_byte(op); end_tr();
    endtask

    task automatic do_write(input int a, input int n, input logic [7:0] base, input bit ok);
        begin_tr();
        tx_byte(8'h02);
        send_addr(a);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = base + 8'(i * 17);
            tx_byte(d);
            if (ok) model[(a + i) % DEPTH] = d;
        end
        end_tr();
    endtask

    task automatic do_read(input int a, input int n, input int hold_at, input string tag);
        logic [7:0] r;
        begin_tr();
        tx_byte(8'h03);
        send_addr(a);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(model[(a + i) % DEPTH]);
            tag_q.push_back(tag);
            xfer(8'h00, 8, (i == 0) ? hold_at : -1, r);
            rx_val = r;
            ->rx_ev;
            #1;
        end
        end_tr();
    endtask

    task automatic rd_status(input int n, input logic [7:0] exp, input string tag);
        logic [7:0] r;
        begin_tr();
        tx_byte(8'h05);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
            xfer(8'h00, 8, -1, r);
            rx_val = r;
            ->rx_ev;
            #1;
        end
        end_tr();
    endtask

    // watchdog
    initial begin
        #1_500_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        #33 rst_n = 1'b1;
        #50;
        chk(oe == 1'b0, "R1 reset output floats", {7'd0, oe}, 8'h00);

        // R11: reset contents
        rd_status(1, 8'h00, "R11 status after reset");
        do_read(0, 2, -1, "R11 array after reset");

        // R1: enable while selected, float after deselect
        begin_tr();
        chk(oe == 1'b1, "R1 selected drives", {7'd0, oe}, 8'h01);
        tx_byte(8'h00);
        end_tr();
        chk(oe == 1'b0, "R1 deselected floats", {7'd0, oe}, 8'h00);

        // R3 / R4: enable, write, flag auto-clear
        cmd1(8'h06);
        rd_status(2, 8'h02, "R3 write-enable set, repeated status");
        do_write(16, 4, 8'h3C, 1);
        rd_status(1, 8'h00, "R4 flag cleared after write");
        do_read(16, 4, -1, "R4 R6 sequential read");

        // R5: no flag, then no permission
        do_write(32, 1, 8'h11, 0);
        do_read(32, 1, -1, "R5 write without flag");
        cmd1(8'h06);
        wr_allow = 1'b0;
        do_write(33, 1, 8'h22, 0);
        wr_allow = 1'b1;
        rd_status(1, 8'h02, "R5 flag kept after refused write");
        do_read(33, 1, -1, "R5 write without permission");
        cmd1(8'h04);
        rd_status(1, 8'h00, "R3 write-disable clears flag");

        // R6: wrap across the top
        cmd1(8'h06);
        do_write(DEPTH - 1, 3, 8'h70, 1);
        do_read(DEPTH - 2, 4, -1, "R6 address wrap");

        // R7: partial byte discarded
        cmd1(8'h06);
        begin_tr();
        tx_byte(8'h02);
        send_addr(64);
        tx_byte(8'h5A);
        xfer(8'hC3, 5, -1, d);
        end_tr();
        model[64] = 8'h5A;
        do_read(64, 2, -1, "R7 partial byte not stored");

        // R9: unknown command
        cmd1(8'h06);
        begin_tr();
        tx_byte(8'hAB); tx_byte(8'h00); tx_byte(8'h40); tx_byte(8'h99);
        end_tr();
        rd_status(1, 8'h02, "R9 unknown command leaves status");
        do_read(64, 1, -1, "R9 unknown command leaves memory");
        cmd1(8'h04);

        // R10: status write
        cmd1(8'h06);
        begin_tr(); tx_byte(8'h01); tx_byte(8'hA7); end_tr();
        rd_status(1, 8'hA4, "R10 status bits written");
        begin_tr(); tx_byte(8'h01); tx_byte(8'h18); end_tr();
        rd_status(1, 8'hA4, "R10 status write refused without flag");

        // R8: hold mid-byte during read and during address
        do_read(16, 2, 3, "R8 read resumes after hold");
        begin_tr();
        tx_byte(8'h03);
        tx_byte(8'h00);
        xfer(8'h11, 8, 5, d);
        exp_q.push_back(model[17]); tag_q.push_back("R8 hold inside address");
        xfer(8'h00, 8, -1, d); rx_val = d; ->rx_ev; #1;
        end_tr();

        // R2: mode 3
        cpol = 1'b1;
        sck = 1'b1; #(4*HALF);
        cmd1(8'h06);
        do_write(128, 2, 8'h96, 1);
        do_read(128, 2, -1, "R2 mode 3 write and read");
        rd_status(1, 8'hA4, "R2 mode 3 status");
        cpol = 1'b0;
        sck = 1'b0; #(4*HALF);
        do_read(128, 1, -1, "R2 mode 0 after mode 3");

        #(4*HALF);
        if (exp_q.size() != 0) chk(1'b0, "scoreboard-leftover", 8'(exp_q.size()), 8'h00);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule